// File: doc/BRIEF.md
# Match-Based Watchdog Reset Timer

This block is a watchdog peripheral on a simple 32-bit register bus. A 32-bit up-counter advances once per tick of a fixed-rate enable input; in the intended system the tick runs at 13 MHz, so a timeout of N seconds is programmed as a compare value of N x 13,000,000. When the counter steps onto the compare value, the block can raise an interrupt flag, change an external match pin, stop counting, and start a system reset pulse. The pulse can be internal only, or internal and external, and its width in ticks is set by its own register.

Software first requests a counter clear and polls the counter register until it reads zero. It then programs the compare value, the match actions and the pulse width, and enables counting. The counter can be frozen while a debug-halt input is high. A reset-cause bit records that the watchdog issued a reset. Only power-on reset clears that bit, so it stays readable after the system comes back up.

Registers are selected by a 3-bit word index:
- 0: interrupt flag
- 1: control
- 2: counter
- 3: match actions
- 4: compare value
- 5: match pin control
- 6: pulse width
- 7: reset cause

Reads are combinational. A write takes effect at the clock edge where `bus_sel_i` and `bus_wr_i` are both high.

Top module: `wdt_match_timer`

## Requirements
- R1: After power-on reset every register reads 0, and `irq_o`, `match_o`, `rst_int_o` and `rst_ext_o` are low.
- R2: While control bit 0 is 1, the counter (index 2) increases by one at each clock edge where `tick_i` is high. It holds its value when control bit 0 is 0 or `tick_i` is low.
- R3: A match event is the counter stepping onto the compare value (index 4). On a match event with match-action bit 0 set, bit 0 of index 0 becomes 1 in the same cycle the counter shows the compare value, and `irq_o` follows that bit. With match-action bit 0 clear, the flag stays 0.
- R4: With match-action bit 2 set, a match event clears control bit 0, and the counter holds at the compare value.
- R5: Writing 1 to bit 0 of index 0 clears the interrupt flag. Writing 0 there leaves it unchanged.
- R6: Writing control bit 1 requests a counter clear. Bit 1 reads 1 and the counter keeps its value until the next tick. At that tick the counter becomes 0 and bit 1 returns to 0.
- R7: While control bit 2 and `dbg_halt_i` are both 1, the counter does not advance. It resumes when `dbg_halt_i` falls.
- R8: Writes to the counter (index 2) and to the reset cause (index 7) are ignored. Bits a register does not define read as 0; this includes control bits above 2 and match-action bit 1.
- R9: Match pin control bits 5:4 choose the action on a match event: 0 none, 1 drive low, 2 drive high, 3 toggle. Bit 0 reads as, and sets, the level of `match_o`.
- R10: With match-action bit 3 set, a match event raises `rst_int_o`. With bit 4 set, it raises both `rst_int_o` and `rst_ext_o`. The pulse lasts (pulse width register + 6) ticks. Starting a pulse sets bit 0 of index 7, which only power-on reset clears.
- R11: Writing match-action bit 5 starts an internal pulse at once, and bit 6 starts an internal and external pulse at once, with the same width and cause rule as R10. Both bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| tick_i | input | 1 | Counter tick enable |
| dbg_halt_i | input | 1 | Debug halt, freezes counter when enabled |
| bus_sel_i | input | 1 | Register access select |
| bus_wr_i | input | 1 | Write strobe |
| bus_addr_i | input | 3 | Register word index |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data of the indexed register |
| irq_o | output | 1 | Match interrupt flag |
| match_o | output | 1 | External match pin |
| rst_int_o | output | 1 | Internal reset pulse, active high |
| rst_ext_o | output | 1 | External reset pulse, active high |

## Verification
The hardest case to reach is the clear request that is still pending. The bench holds `tick_i` low while writing the clear bit. It then reads the counter and the control register before releasing the tick, which shows the request waiting, and reads both again afterwards to see the clear finish. Pulse widths are measured in ticks rather than clock cycles, with the tick running at half rate, so the (width + 6) rule is checked independently of the tick phase. The debug freeze is checked against a stop-on-match compare value, so the frozen and the resumed counter values are both exact.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [2:0] {
    REG_IRQ   = 3'd0,
    REG_CTRL  = 3'd1,
    REG_CNT   = 3'd2,
    REG_MACT  = 3'd3,
    REG_CMP   = 3'd4,
    REG_PIN   = 3'd5,
    REG_WIDTH = 3'd6,
    REG_CAUSE = 3'd7
  } reg_idx_e;

  typedef enum logic [1:0] {
    PIN_KEEP   = 2'd0,
    PIN_LOW    = 2'd1,
    PIN_HIGH   = 2'd2,
    PIN_TOGGLE = 2'd3
  } pin_act_e;

  function automatic logic pin_next(input pin_act_e act, input logic cur);
    case (act)
      PIN_LOW:    return 1'b0;
      PIN_HIGH:   return 1'b1;
      PIN_TOGGLE: return ~cur;
      default:    return cur;
    endcase
  endfunction
endpackage

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             clr_req_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             clr_done_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q, cnt_inc;
  logic             adv;

  always_comb begin
    cnt_inc    = cnt_q + CNT_W'(1);
    adv        = tick_i & run_i & ~clr_req_i;
    clr_done_o = tick_i & clr_req_i;
    hit_o      = adv & (cnt_inc == cmp_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr_done_o) cnt_q <= '0;
    else if (adv)        cnt_q <= cnt_inc;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wdt_rst_pulse.sv
module wdt_rst_pulse #(
  parameter int PW_W        = 16,
  parameter int PULSE_EXTRA = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  input  logic            start_i,
  input  logic            start_ext_i,
  input  logic [PW_W-1:0] width_i,
  output logic            rst_int_o,
  output logic            rst_ext_o,
  output logic            cause_o
);
  localparam int LEN_W = PW_W + 1;

  logic [LEN_W-1:0] left_q;
  logic             ext_q, cause_q, busy, load;

  always_comb begin
    busy = (left_q != '0);
    load = start_i & ~busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      ext_q  <= 1'b0;
    end else if (load) begin
      left_q <= LEN_W'(width_i) + LEN_W'(PULSE_EXTRA);
      ext_q  <= start_ext_i;
    end else if (tick_i && busy) begin
      left_q <= left_q - LEN_W'(1);
    end
  end

  // Power-on reset is the only clear of the cause flag.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cause_q <= 1'b0;
    else if (load) cause_q <= 1'b1;
  end

  assign rst_int_o = busy;
  assign rst_ext_o = busy & ext_q;
  assign cause_o   = cause_q;
endmodule

// File: rtl/wdt_match_timer.sv
module wdt_match_timer
  import wdt_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int PW_W        = 16,
  parameter int PULSE_EXTRA = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_i,
  input  logic        dbg_halt_i,
  input  logic        bus_sel_i,
  input  logic        bus_wr_i,
  input  logic [2:0]  bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  output logic        irq_o,
  output logic        match_o,
  output logic        rst_int_o,
  output logic        rst_ext_o
);
  localparam int DW = 32;

  reg_idx_e         idx;
  logic             wr;
  logic             irq_q, en_q, clr_q, frz_q, pin_q;
  logic [4:0]       mact_q;
  pin_act_e         pin_act_q;
  logic [CNT_W-1:0] cmp_q, cnt_q;
  logic [PW_W-1:0]  width_q;
  logic             run, clr_done, hit, rsrc_q;
  logic             frc_int, frc_ext, start, start_ext;

  always_comb begin
    idx       = reg_idx_e'(bus_addr_i);
    wr        = bus_sel_i & bus_wr_i;
    run       = en_q & ~(frz_q & dbg_halt_i);
    frc_int   = wr && idx == REG_MACT && bus_wdata_i[5];
    frc_ext   = wr && idx == REG_MACT && bus_wdata_i[6];
    start     = (hit & (mact_q[3] | mact_q[4])) | frc_int | frc_ext;
    start_ext = (hit & mact_q[4]) | frc_ext;
  end

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_i(run),
    .clr_req_i(clr_q), .cmp_i(cmp_q), .cnt_o(cnt_q),
    .clr_done_o(clr_done), .hit_o(hit)
  );

  wdt_rst_pulse #(.PW_W(PW_W), .PULSE_EXTRA(PULSE_EXTRA)) u_pulse (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .start_i(start),
    .start_ext_i(start_ext), .width_i(width_q),
    .rst_int_o(rst_int_o), .rst_ext_o(rst_ext_o), .cause_o(rsrc_q)
  );

  // Control: hardware updates first, a bus write in the same cycle wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      clr_q <= 1'b0;
      frz_q <= 1'b0;
    end else begin
      if (clr_done)         clr_q <= 1'b0;
      if (hit && mact_q[2]) en_q  <= 1'b0;
      if (wr && idx == REG_CTRL) begin
        en_q  <= bus_wdata_i[0];
        clr_q <= bus_wdata_i[1];
        frz_q <= bus_wdata_i[2];
      end
    end
  end

  // Interrupt flag: a match sets it, and that wins over a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else if (hit && mact_q[0]) irq_q <= 1'b1;
    else if (wr && idx == REG_IRQ && bus_wdata_i[0]) irq_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mact_q  <= '0;
      cmp_q   <= '0;
      width_q <= '0;
    end else if (wr) begin
      case (idx)
        REG_MACT:  mact_q  <= {bus_wdata_i[4:2], 1'b0, bus_wdata_i[0]};
        REG_CMP:   cmp_q   <= bus_wdata_i[CNT_W-1:0];
        REG_WIDTH: width_q <= bus_wdata_i[PW_W-1:0];
        default: ;
      endcase
    end
  end

  // Match pin: a match event overrides a bus write of the level.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_act_q <= PIN_KEEP;
      pin_q     <= 1'b0;
    end else begin
      if (wr && idx == REG_PIN) begin
        pin_act_q <= pin_act_e'(bus_wdata_i[5:4]);
        pin_q     <= bus_wdata_i[0];
      end
      if (hit) pin_q <= pin_next(pin_act_q, pin_q);
    end
  end

  always_comb begin
    case (idx)
      REG_IRQ:   bus_rdata_o = DW'(irq_q);
      REG_CTRL:  bus_rdata_o = DW'({frz_q, clr_q, en_q});
      REG_CNT:   bus_rdata_o = DW'(cnt_q);
      REG_MACT:  bus_rdata_o = DW'(mact_q);
      REG_CMP:   bus_rdata_o = DW'(cmp_q);
      REG_PIN:   bus_rdata_o = DW'({pin_act_q, 3'b000, pin_q});
      REG_WIDTH: bus_rdata_o = DW'(width_q);
      default:   bus_rdata_o = DW'(rsrc_q);
    endcase
  end

  assign irq_o   = irq_q;
  assign match_o = pin_q;
endmodule

// File: rtl/wdt_match_timer_chk.sv
module wdt_match_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic             dbg_halt_i,
  input logic             irq_o,
  input logic             rst_int_o,
  input logic             rst_ext_o,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp,
  input logic             clr_req,
  input logic             frz,
  input logic             cause
);
  p_irq_at_cmp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> cnt == cmp);

  p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt));

  p_clear_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && clr_req) |=> cnt == '0);

  p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_halt_i && frz && !clr_req) |=> $stable(cnt));

  p_ext_in_int_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_ext_o |-> rst_int_o);

  p_cause_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_int_o |-> cause);
endmodule

bind wdt_match_timer wdt_match_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .dbg_halt_i(dbg_halt_i),
  .irq_o(irq_o), .rst_int_o(rst_int_o), .rst_ext_o(rst_ext_o),
  .cnt(cnt_q), .cmp(cmp_q), .clr_req(clr_q), .frz(frz_q), .cause(rsrc_q)
);

// File: tb/sim_wdt_match_timer.sv
module sim_wdt_match_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1;
  logic        tick_hold = 1'b0, tick_half = 1'b0;
  logic        dbg = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq, mpin, rint, rext;
  int          n_chk = 0, n_fail = 0;
  logic        mon_go = 1'b0;

  typedef struct {
    bit          pins;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #5 clk = ~clk;

  always @(posedge clk) tick <= tick_hold ? 1'b0 : (tick_half ? ~tick : 1'b1);

  wdt_match_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .dbg_halt_i(dbg),
    .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq), .match_o(mpin),
    .rst_int_o(rint), .rst_ext_o(rext)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard and compares, away from the clock edge.
  always @(negedge clk) begin
    if (mon_go && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      chk(it.tag, it.pins ? {28'b0, rext, rint, mpin, irq} : rdata, it.exp);
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    step(1);
    sel = 1; wr = 1; addr = a; wdata = d;
    step(1);
    sel = 0; wr = 0;
  endtask

  task automatic exp_rd(input logic [2:0] a, input logic [31:0] e, input string tag);
    step(1);
    addr = a;
    sb.push_back('{pins: 1'b0, exp: e, tag: tag});
    mon_go = 1;
    step(1);
    mon_go = 0;
  endtask

  // Pin order: {rst_ext, rst_int, match, irq}
  task automatic exp_pins(input logic [3:0] e, input string tag);
    step(1);
    sb.push_back('{pins: 1'b1, exp: {28'b0, e}, tag: tag});
    mon_go = 1;
    step(1);
    mon_go = 0;
  endtask

  // Counts the ticks of one reset pulse and records whether the external line joined it.
  task automatic measure(output int ticks, output bit ext_seen);
    int guard = 0;
    ticks = 0;
    ext_seen = 0;
    while (!rint && guard < 200) begin guard++; step(1); end
    while (rint && guard < 2000) begin
      guard++;
      if (rext) ext_seen = 1;
      if (tick) ticks++;
      step(1);
    end
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int  t;
    bit  e;
    step(4);
    rst_n = 1;
    // R1 reset state
    exp_rd(3'd1, 0, "R1 ctrl");
    exp_rd(3'd2, 0, "R1 counter");
    exp_rd(3'd4, 0, "R1 compare");
    exp_rd(3'd7, 0, "R1 cause");
    exp_pins(4'b0000, "R1 pins");
    // R3 R4 match with interrupt and stop
    bus_wr(3'd4, 20);
    bus_wr(3'd3, 32'h5);
    bus_wr(3'd1, 32'h1);
    step(40);
    exp_rd(3'd2, 20, "R4 counter held at compare");
    exp_rd(3'd0, 1, "R3 flag set");
    exp_rd(3'd1, 0, "R4 enable cleared");
    exp_pins(4'b0001, "R3 irq pin");
    // R5
    bus_wr(3'd0, 0);
    exp_rd(3'd0, 1, "R5 write 0 no effect");
    bus_wr(3'd0, 1);
    exp_rd(3'd0, 0, "R5 cleared");
    // R6 pending clear while tick held low
    tick_hold = 1;
    step(2);
    bus_wr(3'd1, 32'h2);
    exp_rd(3'd2, 20, "R6 counter before tick");
    exp_rd(3'd1, 2, "R6 request pending");
    tick_hold = 0;
    step(4);
    exp_rd(3'd2, 0, "R6 counter cleared");
    exp_rd(3'd1, 0, "R6 request done");
    // R7 freeze, R2 counting
    bus_wr(3'd4, 5);
    bus_wr(3'd3, 32'h4);
    dbg = 1;
    bus_wr(3'd1, 32'h5);
    step(20);
    exp_rd(3'd2, 0, "R7 frozen");
    dbg = 0;
    step(20);
    exp_rd(3'd2, 5, "R2 R7 resumed to compare");
    // R8
    bus_wr(3'd2, 32'h1234);
    exp_rd(3'd2, 5, "R8 counter write ignored");
    bus_wr(3'd7, 1);
    exp_rd(3'd7, 0, "R8 cause write ignored");
    bus_wr(3'd1, 32'hFFFF_FFF8);
    exp_rd(3'd1, 0, "R8 ctrl undefined bits");
    bus_wr(3'd3, 32'hFFFF_FF9F);
    exp_rd(3'd3, 32'h1D, "R8 match-action undefined bits");
    exp_pins(4'b0000, "R8 no pulse");
    bus_wr(3'd3, 0);
    // R9 R10 match-driven reset pulse
    bus_wr(3'd1, 32'h2);
    step(3);
    bus_wr(3'd6, 3);
    bus_wr(3'd5, 32'h20);
    bus_wr(3'd3, 32'h14);
    exp_rd(3'd5, 32'h20, "R9 pin control");
    bus_wr(3'd1, 32'h1);
    measure(t, e);
    chk("R10 pulse ticks", t, 9);
    chk("R10 external joined", e, 1);
    exp_rd(3'd7, 1, "R10 cause set");
    exp_rd(3'd5, 32'h21, "R9 pin driven high");
    exp_rd(3'd0, 0, "R3 no flag without enable");
    exp_pins(4'b0010, "R9 R10 pins after pulse");
    bus_wr(3'd5, 32'h0);
    exp_pins(4'b0000, "R9 pin written low");
    // R11 forced pulses at half tick rate
    tick_half = 1;
    bus_wr(3'd3, 32'h40);
    measure(t, e);
    chk("R11 forced ext ticks", t, 9);
    chk("R11 forced ext line", e, 1);
    exp_rd(3'd3, 0, "R11 force bits read 0");
    bus_wr(3'd3, 32'h20);
    measure(t, e);
    chk("R11 forced int ticks", t, 9);
    chk("R11 forced int only", e, 0);
    exp_rd(3'd7, 1, "R10 cause survives");
    step(4);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule